// File: doc/BRIEF.md
# Geared DDR Output Serializer

This block turns parallel words from slower logic into one serial stream at one bit per cycle of a bit-rate clock. Downstream, adjacent bits are meant to land on opposite edges of a double-data-rate pad. A forwarded clock runs with the stream, and its waveform follows the chosen gearing. A two-bit mode input picks a 2-, 4- or 7-bit word. Bit 0 goes out first. The block asks for the next word with a single-cycle request strobe, and words follow one another with no idle cycles between them.

The controller is a three-state machine:
- HOLD is the reset state.
- PRIME requests the first word.
- SHIFT sends bits and reloads at each word boundary.

The transitions are:
- HOLD→PRIME on the first clock edge after reset is released.
- PRIME→SHIFT when the first word is captured.
- SHIFT→SHIFT on every edge, either shifting or reloading.
- Any state→HOLD on reset.

Mode and data are sampled only at the edge that captures a word. A mode change therefore takes effect at the next word boundary.

Top module: `ddr_gear_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `word_req` and `fwd_clk` are all 0.
- R2: In the first cycle after reset is released, `word_req` is 1 and `ser_out` is 0. The word present in that cycle is captured at its closing edge.
- R3: The `mode` encoding is 2'b00 for 2:1, 2'b01 for 4:1 and 2'b10 for 7:1. The value 2'b11 behaves as 2:1.
- R4: Each captured word goes out on `ser_out` one bit per clock, starting with bit 0, beginning in the cycle after the capture edge. Only the low `ratio` bits are sent.
- R5: `word_req` is 1 exactly in the cycle that carries the last bit of the current word. The next word is captured at the edge closing that cycle, so no gap appears between words.
- R6: `par_data` and `mode` have no effect at edges where `word_req` was 0.
- R7: `fwd_clk` is 1 during the first ceil(ratio/2) bits of each word and 0 for the rest:
  - 2:1 gives 1 high, 1 low.
  - 4:1 gives 2 high, 2 low.
  - 7:1 gives 4 high, 3 low.
  - It is 0 in HOLD and PRIME.
- R8: A reset asserted in the middle of a word forces the outputs to 0 at once. Afterwards the block restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Gearing select, sampled at word capture |
| par_data | input | WORD_W | Parallel word, bit 0 sent first |
| word_req | output | 1 | Word request, high in the cycle before capture |
| ser_out | output | 1 | Serial data stream |
| fwd_clk | output | 1 | Forwarded clock aligned to word boundaries |

## Verification
The assertions take some things for granted about the inputs:
- `rst_n` is the only asynchronous input.
- `par_data` and `mode` are settled before the edge that closes a `word_req` cycle.
- After reset the latched mode always decodes to a ratio of 2, 4 or 7.

The bench respects all of this by changing inputs only on the falling clock edge. In non-request cycles it deliberately drives scrambled words and modes, including the reserved code, so that sampling outside a capture edge would show up as a wrong bit or clock level.

// File: rtl/gear_pkg.sv
package gear_pkg;

    typedef enum logic [1:0] {
        GEAR_2   = 2'b00,
        GEAR_4   = 2'b01,
        GEAR_7   = 2'b10,
        GEAR_RSV = 2'b11
    } gear_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'b00,
        ST_PRIME = 2'b01,
        ST_SHIFT = 2'b10
    } ser_state_e;

    // bits per word for a gearing mode; reserved code falls back to 2:1
    function automatic int unsigned gear_ratio(gear_mode_e m);
        case (m)
            GEAR_4:  return 4;
            GEAR_7:  return 7;
            default: return 2;
        endcase
    endfunction

    // bits per word during which the forwarded clock is high
    function automatic int unsigned gear_high(gear_mode_e m);
        return (gear_ratio(m) + 1) / 2;
    endfunction

endpackage

// File: rtl/gear_ctrl.sv
module gear_ctrl
    import gear_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gear_mode_e       mode_i,
    output logic             load_o,
    output logic             shift_o,
    output logic [CNT_W-1:0] cnt_o,
    output gear_mode_e       mode_q_o
);

    ser_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    gear_mode_e       mode_q;
    logic             last_bit;

    assign last_bit = (cnt_q == CNT_W'(gear_ratio(mode_q) - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD:  state_nxt = ST_PRIME;
            ST_PRIME: state_nxt = ST_SHIFT;
            ST_SHIFT: state_nxt = ST_SHIFT;
            default:  state_nxt = ST_HOLD;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        unique case (state_q)
            ST_HOLD:  ;
            ST_PRIME: load_o = 1'b1;
            ST_SHIFT: begin
                shift_o = 1'b1;
                load_o  = last_bit;
            end
            default:  ;
        endcase
    end

    // bit counter and latched gearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= GEAR_2;
        end else if (load_o) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
        end else if (shift_o) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign mode_q_o = mode_q;

    // R5
    capture_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (shift_o && cnt_q == '0));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> $stable(mode_q));

    // R2
    prime_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o && !shift_o) |=> (load_o && !shift_o));

endmodule

// File: rtl/gear_shift.sv
module gear_shift #(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              ser_o
);

    logic [WORD_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sreg_q <= '0;
        else if (load_i)  sreg_q <= data_i;
        else if (shift_i) sreg_q <= sreg_q >> 1;
    end

    assign ser_o = shift_i & sreg_q[0];

    // R4
    lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (sreg_q[WORD_W-2:0] == $past(sreg_q[WORD_W-1:1])));

endmodule

// File: rtl/gear_clkgen.sv
module gear_clkgen
    import gear_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  gear_mode_e       mode_i,
    output logic             fwd_clk_o
);

    assign fwd_clk_o = active_i && (cnt_i < CNT_W'(gear_high(mode_i)));

    // R7
    clk_rise_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_clk_o) |-> (cnt_i == '0));

    // R7
    clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !fwd_clk_o);

endmodule

// File: rtl/ddr_gear_serializer.sv
module ddr_gear_serializer
    import gear_pkg::*;
#(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] par_data,
    output logic              word_req,
    output logic              ser_out,
    output logic              fwd_clk
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic             load, shift;
    logic [CNT_W-1:0] cnt;
    gear_mode_e       mode_q;

    gear_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (gear_mode_e'(mode)),
        .load_o   (load),
        .shift_o  (shift),
        .cnt_o    (cnt),
        .mode_q_o (mode_q)
    );

    gear_shift #(.WORD_W(WORD_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .data_i  (par_data),
        .ser_o   (ser_out)
    );

    gear_clkgen #(.CNT_W(CNT_W)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (shift),
        .cnt_i     (cnt),
        .mode_i    (mode_q),
        .fwd_clk_o (fwd_clk)
    );

    assign word_req = load;

    // R1
    quiet_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!word_req && !ser_out && !fwd_clk));

    // R5
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && shift) |=> !word_req);

endmodule

// File: tb/ddr_gear_serializer_tb_top.sv
module ddr_gear_serializer_tb_top;

    localparam int WORD_W = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode;
    logic [WORD_W-1:0] par_data;
    logic              word_req, ser_out, fwd_clk;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          widx     = 0;
    logic [15:0] lfsr     = 16'hACE1;
    logic [1:0]  exp_q[$];   // {ser_out, fwd_clk} per expected cycle

    always #10 clk = ~clk;

    ddr_gear_serializer #(.WORD_W(WORD_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .par_data (par_data),
        .word_req (word_req),
        .ser_out  (ser_out),
        .fwd_clk  (fwd_clk)
    );

    task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // R3: 01 -> 4, 10 -> 7, 00 and 11 -> 2
    function automatic int ratio_of(logic [1:0] m);
        case (m)
            2'b01:   return 4;
            2'b10:   return 7;
            default: return 2;
        endcase
    endfunction

    function automatic logic [1:0] mode_for(int i);
        if (i < 8)  return 2'b00;
        if (i < 16) return 2'b01;
        if (i < 24) return 2'b10;
        if (i < 28) return 2'b11;
        return 2'(i % 3);
    endfunction

    task automatic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // driver: present a word and push its expected bits and clock levels
    task automatic push_word();
        logic [1:0] m;
        int r;
        next_rand();
        m        = mode_for(widx);
        r        = ratio_of(m);
        mode     = m;
        par_data = lfsr[WORD_W-1:0];
        for (int b = 0; b < r; b++)
            exp_q.push_back({par_data[b], logic'(b < (r + 1) / 2)});
        widx++;
    endtask

    // R6: scrambled inputs outside capture edges must be ignored
    task automatic scramble();
        next_rand();
        par_data = ~lfsr[WORD_W-1:0];
        mode     = lfsr[9:8];
    endtask

    // monitor: pop one expected cycle and compare, then drive
    task automatic step();
        logic [1:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(ser_out == e[1], "R4 ser_out bit order", ser_out, e[1]);
            chk(fwd_clk == e[0], "R7 fwd_clk level", fwd_clk, e[0]);
            chk(word_req == (exp_q.size() == 0), "R5 word_req on last bit",
                word_req, logic'(exp_q.size() == 0));
        end else begin
            chk(word_req == 1'b1, "R2 first request", word_req, 1'b1);
            chk(ser_out == 1'b0, "R2 idle ser_out", ser_out, 1'b0);
            chk(fwd_clk == 1'b0, "R7 idle fwd_clk", fwd_clk, 1'b0);
        end
        if (word_req) push_word();
        else          scramble();
    endtask

    task automatic check_quiet(input string tag);
        chk(ser_out == 1'b0, tag, ser_out, 1'b0);
        chk(word_req == 1'b0, tag, word_req, 1'b0);
        chk(fwd_clk == 1'b0, tag, fwd_clk, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        mode     = 2'b10;
        par_data = '1;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R1 quiet in reset");
        end
        rst_n = 1'b1;
        while (widx < 40) begin
            @(negedge clk);
            step();
        end
        // reach the middle of a word, then reset
        do begin
            @(negedge clk);
            step();
        end while (exp_q.size() != 3);
        rst_n = 1'b0;
        #1;
        check_quiet("R8 mid-word reset");
        exp_q.delete();
        @(negedge clk);
        check_quiet("R8 held in reset");
        rst_n = 1'b1;
        while (widx < 70) begin
            @(negedge clk);
            step();
        end
        finish_run();
    end

endmodule